// File: doc/BRIEF.md
# Byte-Matrix Bit Transpose and Gather Unit

This unit works on 64-bit operands seen as eight bytes, byte 0 being the least significant. A one-bit opcode picks one of two operations. The transpose operation treats operand A as an 8x8 bit matrix whose rows are its bytes and returns the flipped matrix: output byte j collects bit j of every input byte. The gather operation reads each byte of operand B as a bit index into operand A and packs the eight selected bits into the low byte of the result.

The unit is a one-stage pipeline slot for a processor's execute path. When the input strobe is high at a clock edge, the result register loads the new value and the output strobe rises for that cycle. When the input strobe is low, the register keeps its last value. Flag generation and instruction decode are handled elsewhere.

Top module: `bitmat_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and out_result are cleared to zero on that edge.
- R2: out_valid equals the value in_valid had at the previous clock edge.
- R3: With in_op = 0 (transpose), bit i of result byte j equals bit j of byte i of opnd_a, for all i, j in 0..7; result bit position is 8*j+i.
- R4: Feeding a transpose result back as opnd_a of a second transpose returns the original operand.
- R5: With in_op = 1 (gather), result bit k (k = 0..7) equals opnd_a[s], where s is the unsigned value of opnd_b[8k+7:8k] and s < 64.
- R6: In gather mode, a selector byte with value 64 or more makes its result bit 0.
- R7: In gather mode, result bits 63:8 are zero.
- R8: When in_valid is low at a clock edge, out_result keeps its value.
- R9: In transpose mode the value of opnd_b has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 1 | 0 = transpose, 1 = gather |
| opnd_a | input | 64 | Matrix operand or gather source |
| opnd_b | input | 64 | Eight selector bytes (gather only) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Registered result |

## Verification
The checker watches on every cycle the strobe latency, the hold of the result while idle, the reset clearing, the zero upper bits and out-of-range selector handling in gather mode, and one representative transposed bit pair. The full bit mapping of both operations, the involution of a double transpose and the indifference of the transpose to operand B need whole-word reference values, so only the bench's scoreboard scenarios, with directed corner patterns and random operands, can show them.

// File: rtl/bitmat_pkg.sv
// Package: shared geometry and opcode encoding for the bit-matrix unit.
// Assumes a square matrix: the number of bytes equals the bits per byte.
package bitmat_pkg;
    localparam int unsigned ELEM   = 8;
    localparam int unsigned DATA_W = ELEM * ELEM;

    typedef enum logic {
        OP_TRANSPOSE = 1'b0,
        OP_GATHER    = 1'b1
    } bm_op_e;
endpackage

// File: rtl/bm_transpose.sv
// Module: bm_transpose
// Flips an ELEM x ELEM bit matrix whose rows are the operand's lanes.
// Output lane j, bit i is input lane i, bit j. Pure wiring, no logic depth.
module bm_transpose #(
    parameter int unsigned ELEM = 8,
    localparam int unsigned DATA_W = ELEM * ELEM
) (
    input  logic [DATA_W-1:0] mat_in,
    output logic [DATA_W-1:0] mat_out
);
    for (genvar row = 0; row < ELEM; row++) begin : g_row
        for (genvar col = 0; col < ELEM; col++) begin : g_col
            // route one matrix cell to its mirrored position
            assign mat_out[col*ELEM + row] = mat_in[row*ELEM + col];
        end
    end
endmodule

// File: rtl/bm_gather.sv
// Module: bm_gather
// Picks ELEM single bits from src, each addressed by one ELEM-bit lane of sel.
// Lane k drives result bit k; an index at or beyond DATA_W gives 0.
// Upper result bits are tied to zero.
module bm_gather #(
    parameter int unsigned ELEM = 8,
    localparam int unsigned DATA_W = ELEM * ELEM,
    localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] sel,
    output logic [DATA_W-1:0] picked
);
    logic [ELEM-1:0] lane_bits;

    for (genvar k = 0; k < ELEM; k++) begin : g_lane
        logic [ELEM-1:0]  idx;
        logic             in_range;
        assign idx      = sel[k*ELEM +: ELEM];
        assign in_range = (idx < ELEM'(DATA_W));
        // select one source bit, forced low for an out-of-range index
        assign lane_bits[k] = in_range ? src[idx[IDX_W-1:0]] : 1'b0;
    end

    assign picked = {{(DATA_W-ELEM){1'b0}}, lane_bits};
endmodule

// File: rtl/bm_result_reg.sv
// Module: bm_result_reg
// Result and strobe register. Loads only on a valid request,
// otherwise holds. Synchronous active-low reset clears both.
module bm_result_reg #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] nxt,
    output logic              vld_q,
    output logic [DATA_W-1:0] res_q
);
    // register the strobe every cycle, the data only on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= load;
            if (load) res_q <= nxt;
        end
    end
endmodule

// File: rtl/bitmat_unit.sv
// Module: bitmat_unit (top)
// Byte-matrix transpose and byte-indexed bit gather with a one-cycle
// registered result. Assumes in_op is stable with in_valid.
module bitmat_unit
    import bitmat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    logic [DATA_W-1:0] tr_val;
    logic [DATA_W-1:0] ga_val;
    logic [DATA_W-1:0] nxt_val;
    bm_op_e            op;

    assign op = bm_op_e'(in_op);

    bm_transpose #(.ELEM(ELEM)) u_tr (
        .mat_in  (opnd_a),
        .mat_out (tr_val)
    );

    bm_gather #(.ELEM(ELEM)) u_ga (
        .src    (opnd_a),
        .sel    (opnd_b),
        .picked (ga_val)
    );

    // choose the operation result by opcode
    always_comb begin
        unique case (op)
            OP_GATHER:    nxt_val = ga_val;
            default:      nxt_val = tr_val;
        endcase
    end

    bm_result_reg #(.DATA_W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_valid),
        .nxt   (nxt_val),
        .vld_q (out_valid),
        .res_q (out_result)
    );
endmodule

// File: rtl/bitmat_unit_chk.sv
// Module: bitmat_unit_chk
// Port-level properties for bitmat_unit, attached by bind below.
module bitmat_unit_chk
    import bitmat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_op,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0));

    // R2
    strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    transpose_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_TRANSPOSE) |=>
            (out_result[ELEM] == $past(opnd_a[1])));

    // R6
    gather_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_GATHER && opnd_b[ELEM-1:0] >= ELEM'(DATA_W))
            |=> !out_result[0]);

    // R7
    gather_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_GATHER) |=> (out_result[DATA_W-1:ELEM] == '0));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
endmodule

bind bitmat_unit bitmat_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/bitmat_unit_bench.sv
// Scoreboard bench: the driver queues expected results, the monitor
// pops and compares them whenever out_valid is seen.
module bitmat_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_res = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bitmat_unit u_bitmat_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [63:0] ref_flip(input logic [63:0] a);
        logic [63:0] r = '0;
        for (int byte_i = 0; byte_i < 8; byte_i++)
            for (int bit_j = 0; bit_j < 8; bit_j++)
                r[8*bit_j + byte_i] = a[8*byte_i + bit_j];
        return r;
    endfunction

    function automatic logic [63:0] ref_pick(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            int s = int'(b[8*k +: 8]);
            r[k] = (s < 64) ? a[s] : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic op, input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        opnd_a   = a;
        opnd_b   = b;
        exp_q.push_back(op ? ref_pick(a, b) : ref_flip(a));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a   = {$urandom, $urandom};
            opnd_b   = {$urandom, $urandom};
            in_op    = 1'(i);
        end
    endtask

    // monitor: compare each valid result; check hold while idle (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R2 got unexpected valid exp none");
                end else begin
                    check(tag_q.pop_front(), out_result, exp_q.pop_front());
                end
            end else begin
                check("R8", out_result, last_res);
            end
            last_res = out_result;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] mid;
        logic [63:0] orig;
        // R1: reset state, with in_valid driven high during reset
        in_valid = 1'b1;
        opnd_a   = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", out_result, 64'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        idle(2);

        // R3: directed transpose patterns
        issue(1'b0, 64'h0000_0000_0000_00FF, '0, "R3");
        issue(1'b0, 64'h8040_2010_0804_0201, '0, "R3");
        issue(1'b0, 64'h0102_0408_1020_4080, '0, "R3");
        issue(1'b0, 64'hFF00_0000_0000_0001, '0, "R3");
        issue(1'b0, 64'h0123_4567_89AB_CDEF, '0, "R3");
        idle(2);
        // R9: same operand A with different B must give same result
        issue(1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        issue(1'b0, 64'h0123_4567_89AB_CDEF, 64'h3F3F_0000_8080_0101, "R9");

        // R5: gather in-range selectors
        issue(1'b1, 64'h8000_0000_0000_0001, 64'h3F00_3F00_3F00_3F00, "R5");
        issue(1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0706_0504_0302_0100, "R5");
        issue(1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h3830_2820_1810_0800, "R5");
        // R6: out-of-range selectors (64, 255, 128)
        issue(1'b1, '1, 64'h40FF_8041_3F00_C040, "R6");
        issue(1'b1, '1, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        // R7: all ones source, full-range selectors, upper bits stay zero
        issue(1'b1, '1, 64'h0102_0304_0506_0708, "R7");
        idle(3);

        // R4: double transpose returns the operand
        for (int t = 0; t < 16; t++) begin
            orig = {$urandom, $urandom};
            issue(1'b0, orig, {$urandom, $urandom}, "R3");
            idle(1);
            mid = out_result;
            issue(1'b0, mid, '0, "R4");
            void'(exp_q.pop_back());
            exp_q.push_back(orig);
            idle(1);
        end

        // random mix, back to back (R2) with gaps (R8)
        for (int t = 0; t < 200; t++) begin
            logic op = 1'($urandom);
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom} & 64'h7F7F_7F7F_7F7F_7F7F;
            issue(op, a, b, op ? "R5" : "R3");
            if ($urandom % 4 == 0) idle(1);
        end
        idle(3);

        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 got %0d pending exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule